// File: doc/BRIEF.md
# Two-Oscillator Vernier Interval Measurement Controller

This block measures the time between a start event and a stop event by running two gated oscillators with slightly different periods. When start is accepted, the block enables the slow oscillator and counts its rising edges. When stop arrives, it freezes that coarse count and enables the fast oscillator. It then counts fast edges until a fast edge lands on, or overtakes, a slow edge. The interval equals coarse × Tslow + fine × (Tslow − Tfast).

Both oscillator edge streams enter through a synchronizer and a rising-edge detector clocked by the system clock. The phase comparator decides catch-up from the order of the detected edges. After catch-up, the block gates both oscillators off and holds the two counts. It forms a result word, coarse × RATIO + fine, where RATIO = Tslow/(Tslow − Tfast) is a parameter. It pulses done and then waits for the next start. If the fast oscillator never catches up, a fine-count limit aborts the measurement.

Top module: `tdc_vernier_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every output to zero, both counters included, and returns the block to idle, even in the middle of a measurement.
- R2: A start seen at an edge while idle raises slow_en from that edge and clears both counts, valid, sat, timeout_err and meas_word. Every detected slow rising edge then increments coarse_count. A rise that is first high on slow_edge at edge k is detected at edge k+SYNC_STAGES; fast_edge has the same latency.
- R3: A stop seen at an edge during the coarse phase raises fast_en from that edge and freezes coarse_count. A slow rise detected at that same edge is still counted.
- R4: In the fine phase each detected fast rise increments fine_count. Catch-up occurs when a fast rise is detected at the same edge as a slow rise, or when a fast rise follows another fast rise with no slow rise between them. The instant stop is accepted counts as a slow rise for this rule, and the catching fast rise is counted.
- R5: At catch-up, slow_en and fast_en fall and done is high for exactly one cycle. valid goes high, and coarse_count, fine_count and meas_word hold until the next accepted start.
- R6: On a valid result, meas_word = coarse_count × RATIO + fine_count.
- R7: coarse_count never wraps: a slow rise at the all-ones value leaves it there and sets sat. When sat is set, or when the sum exceeds RESULT_W bits, meas_word becomes all ones.
- R8: A non-catching fast rise detected while fine_count equals TIMEOUT_FINE aborts the measurement. Both enables fall, done pulses once, timeout_err goes high, valid stays low, meas_word is zero and fine_count stays at TIMEOUT_FINE.
- R9: A catching fast rise detected while fine_count equals TIMEOUT_FINE is a catch-up, not a timeout, and gives fine_count = TIMEOUT_FINE+1.
- R10: A stop while idle has no effect, and so does a start while a measurement is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start event, sampled per clock |
| stop | input | 1 | Stop event, sampled per clock |
| slow_edge | input | 1 | Slow oscillator output |
| fast_edge | input | 1 | Fast oscillator output |
| slow_en | output | 1 | Slow oscillator enable |
| fast_en | output | 1 | Fast oscillator enable |
| coarse_count | output | COARSE_W | Slow periods counted |
| fine_count | output | FINE_W | Fast periods counted |
| meas_word | output | RESULT_W | Combined result word |
| done | output | 1 | One-cycle end-of-measurement pulse |
| valid | output | 1 | Result held is a good catch-up result |
| sat | output | 1 | Coarse counter or result word saturated |
| timeout_err | output | 1 | Measurement aborted by the fine-count limit |

## Verification
Two pairs of events can fall on the same edge. A catching fast edge can arrive exactly when the fine count reaches its limit. A directed case sets the fast oscillator's lag to TIMEOUT_FINE period differences, and the bench expects a catch-up with fine count TIMEOUT_FINE+1 and no error. A lag one step longer must give the timeout. A stop can also land on the edge where a slow rise is detected. That case is set up by aligning the stop with a slow detection, and the bench's edge-order model, also applied to random oscillator periods and phases, judges whether that rise is counted.

// File: rtl/tdc_vernier_pkg.sv
package tdc_vernier_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COARSE = 2'd1,
        ST_FINE   = 2'd2
    } tdc_state_e;

endpackage

// File: rtl/tdc_edge_detect.sv
module tdc_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d = det_q;
        det_d.sync[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            det_d.sync[i] = det_q.sync[i-1];
        end
        det_d.last = det_q.sync[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) det_q <= '0;
        else     det_q <= det_d;
    end

    assign rise = det_q.sync[STAGES-1] & ~det_q.last;

endmodule

// File: rtl/tdc_sat_counter.sv
module tdc_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         at_max
);
    localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                          cnt_d = '0;
        else if (inc && cnt_q != MAX_VAL) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count  = cnt_q;
    assign at_max = (cnt_q == MAX_VAL);

    // R7: once at the top value, the count stays there until cleared
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        at_max && !clr |=> at_max);

    // R2: without a clear the count never goes down
    assert_count_monotone_R2: assert property (@(posedge clk) disable iff (rst)
        !clr |=> count >= $past(count));

endmodule

// File: rtl/tdc_phase_cmp.sv
module tdc_phase_cmp (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic active,
    input  logic s_rise,
    input  logic f_rise,
    output logic catch_up
);
    logic seen_d, seen_q;

    always_comb begin
        seen_d = seen_q;
        if (arm)              seen_d = 1'b1;
        else if (active) begin
            if (f_rise)       seen_d = 1'b0;
            else if (s_rise)  seen_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= seen_d;
    end

    assign catch_up = active & f_rise & (s_rise | ~seen_q);

endmodule

// File: rtl/tdc_word_calc.sv
module tdc_word_calc #(
    parameter int COARSE_W = 8,
    parameter int FINE_W   = 6,
    parameter int RESULT_W = 15,
    parameter int RATIO    = 32
) (
    input  logic [COARSE_W-1:0] coarse,
    input  logic [FINE_W-1:0]   fine,
    input  logic                coarse_sat,
    output logic [RESULT_W-1:0] word,
    output logic                word_sat
);
    localparam int RATIO_W = $clog2(RATIO + 1);
    localparam int SUM_W   = COARSE_W + RATIO_W + FINE_W + RESULT_W;
    localparam logic [SUM_W-1:0] WORD_MAX = (SUM_W'(1) << RESULT_W) - SUM_W'(1);

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(coarse) * SUM_W'(RATIO) + SUM_W'(fine);
        if (coarse_sat || sum > WORD_MAX) begin
            word     = {RESULT_W{1'b1}};
            word_sat = 1'b1;
        end else begin
            word     = sum[RESULT_W-1:0];
            word_sat = 1'b0;
        end
    end

endmodule

// File: rtl/tdc_vernier_ctrl.sv
module tdc_vernier_ctrl
    import tdc_vernier_pkg::*;
#(
    parameter int COARSE_W     = 8,
    parameter int FINE_W       = 6,
    parameter int RESULT_W     = 15,
    parameter int RATIO        = 32,
    parameter int TIMEOUT_FINE = 40,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                stop,
    input  logic                slow_edge,
    input  logic                fast_edge,
    output logic                slow_en,
    output logic                fast_en,
    output logic [COARSE_W-1:0] coarse_count,
    output logic [FINE_W-1:0]   fine_count,
    output logic [RESULT_W-1:0] meas_word,
    output logic                done,
    output logic                valid,
    output logic                sat,
    output logic                timeout_err
);
    localparam int NUM_OSC = 2;
    localparam int SLOW_IX = 0;
    localparam int FAST_IX = 1;
    localparam logic [FINE_W-1:0] FINE_LIMIT = FINE_W'(TIMEOUT_FINE);

    typedef struct packed {
        tdc_state_e          state;
        logic                slow_en;
        logic                fast_en;
        logic                done;
        logic                valid;
        logic                err;
        logic                sat;
        logic [RESULT_W-1:0] word;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [NUM_OSC-1:0] osc_in;
    logic [NUM_OSC-1:0] osc_rise;
    logic               s_rise, f_rise;
    logic               coarse_clr, coarse_inc, coarse_at_max;
    logic               fine_clr, fine_inc, fine_at_max;
    logic               arm, catch_up;
    logic [FINE_W-1:0]  fine_plus;
    logic [RESULT_W-1:0] calc_word;
    logic               calc_sat;

    assign osc_in[SLOW_IX] = slow_edge;
    assign osc_in[FAST_IX] = fast_edge;

    for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
        tdc_edge_detect #(.STAGES(SYNC_STAGES)) u_det (
            .clk  (clk),
            .rst  (rst),
            .din  (osc_in[g]),
            .rise (osc_rise[g])
        );
    end

    assign s_rise = osc_rise[SLOW_IX];
    assign f_rise = osc_rise[FAST_IX];

    tdc_sat_counter #(.W(COARSE_W)) u_coarse (
        .clk    (clk),
        .rst    (rst),
        .clr    (coarse_clr),
        .inc    (coarse_inc),
        .count  (coarse_count),
        .at_max (coarse_at_max)
    );

    tdc_sat_counter #(.W(FINE_W)) u_fine (
        .clk    (clk),
        .rst    (rst),
        .clr    (fine_clr),
        .inc    (fine_inc),
        .count  (fine_count),
        .at_max (fine_at_max)
    );

    tdc_phase_cmp u_phase (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .active   (ctrl_q.state == ST_FINE),
        .s_rise   (s_rise),
        .f_rise   (f_rise),
        .catch_up (catch_up)
    );

    assign fine_plus = fine_count + FINE_W'(1);

    tdc_word_calc #(
        .COARSE_W (COARSE_W),
        .FINE_W   (FINE_W),
        .RESULT_W (RESULT_W),
        .RATIO    (RATIO)
    ) u_word (
        .coarse     (coarse_count),
        .fine       (fine_plus),
        .coarse_sat (ctrl_q.sat),
        .word       (calc_word),
        .word_sat   (calc_sat)
    );

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        coarse_clr  = 1'b0;
        coarse_inc  = 1'b0;
        fine_clr    = 1'b0;
        fine_inc    = 1'b0;
        arm         = 1'b0;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctrl_d.state   = ST_COARSE;
                    ctrl_d.slow_en = 1'b1;
                    ctrl_d.fast_en = 1'b0;
                    ctrl_d.valid   = 1'b0;
                    ctrl_d.err     = 1'b0;
                    ctrl_d.sat     = 1'b0;
                    ctrl_d.word    = '0;
                    coarse_clr     = 1'b1;
                    fine_clr       = 1'b1;
                end
            end
            ST_COARSE: begin
                if (s_rise) begin
                    coarse_inc = 1'b1;
                    if (coarse_at_max) ctrl_d.sat = 1'b1;
                end
                if (stop) begin
                    ctrl_d.state   = ST_FINE;
                    ctrl_d.fast_en = 1'b1;
                    arm            = 1'b1;
                end
            end
            ST_FINE: begin
                if (f_rise) begin
                    if (catch_up) begin
                        fine_inc       = 1'b1;
                        ctrl_d.state   = ST_IDLE;
                        ctrl_d.slow_en = 1'b0;
                        ctrl_d.fast_en = 1'b0;
                        ctrl_d.done    = 1'b1;
                        ctrl_d.valid   = 1'b1;
                        ctrl_d.word    = calc_word;
                        ctrl_d.sat     = ctrl_q.sat | calc_sat;
                    end else if (fine_count == FINE_LIMIT || fine_at_max) begin
                        ctrl_d.state   = ST_IDLE;
                        ctrl_d.slow_en = 1'b0;
                        ctrl_d.fast_en = 1'b0;
                        ctrl_d.done    = 1'b1;
                        ctrl_d.err     = 1'b1;
                        ctrl_d.word    = '0;
                    end else begin
                        fine_inc = 1'b1;
                    end
                end
            end
            default: begin
                ctrl_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign slow_en     = ctrl_q.slow_en;
    assign fast_en     = ctrl_q.fast_en;
    assign meas_word   = ctrl_q.word;
    assign done        = ctrl_q.done;
    assign valid       = ctrl_q.valid;
    assign sat         = ctrl_q.sat;
    assign timeout_err = ctrl_q.err;

    // R5: done lasts one cycle
    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: both oscillators are gated off once the result is reported
    assert_done_gates_osc_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !slow_en && !fast_en);

    // R3: the fast oscillator runs only while the slow one runs
    assert_fast_needs_slow_R3: assert property (@(posedge clk) disable iff (rst)
        fast_en |-> slow_en);

    // R3: the coarse count is frozen during the fine phase
    assert_coarse_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        fast_en |=> $stable(coarse_count));

    // R8: an aborted measurement is never marked valid
    assert_timeout_invalid_R8: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> !valid);

    // R10: stop while idle does not start the fine phase
    assert_idle_stop_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        !slow_en && stop |=> !fast_en);

    // R4: the fine count only moves while the fast oscillator is enabled
    assert_fine_only_when_fast_R4: assert property (@(posedge clk) disable iff (rst)
        !fast_en && !(start && !slow_en) |=> $stable(fine_count));

endmodule

// File: tb/tdc_vernier_ctrl_tb_top.sv
module tdc_vernier_ctrl_tb_top;

    localparam int CW   = 8;
    localparam int FW   = 6;
    localparam int RW   = 15;
    localparam int K    = 32;
    localparam int TO   = 40;
    localparam int NSYN = 2;
    localparam int CMAX = (1 << CW) - 1;
    localparam int WMAX = (1 << RW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, stop = 1'b0, slow_edge = 1'b0, fast_edge = 1'b0;
    logic slow_en, fast_en, done, valid, sat, timeout_err;
    logic [CW-1:0] coarse_count;
    logic [FW-1:0] fine_count;
    logic [RW-1:0] meas_word;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    tdc_vernier_ctrl #(
        .COARSE_W(CW), .FINE_W(FW), .RESULT_W(RW), .RATIO(K),
        .TIMEOUT_FINE(TO), .SYNC_STAGES(NSYN)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .slow_edge(slow_edge), .fast_edge(fast_edge),
        .slow_en(slow_en), .fast_en(fast_en),
        .coarse_count(coarse_count), .fine_count(fine_count),
        .meas_word(meas_word), .done(done), .valid(valid),
        .sat(sat), .timeout_err(timeout_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit wave(input int e, input int s, input int p);
        if (e < s) return 1'b0;
        return ((e - s) % p) < (p / 2);
    endfunction

    function automatic bit det(input int t, input int s, input int p);
        if (t < s + NSYN) return 1'b0;
        return ((t - s - NSYN) % p) == 0;
    endfunction

    task automatic idle_cycles(input int n);
        start = 0; stop = 0; slow_edge = 0; fast_edge = 0;
        repeat (n) @(negedge clk);
    endtask

    // One measurement. Edge 0 carries start, edge d carries stop.
    // The slow wave begins at edge 1+a with period ps; the fast one at d+1+b with period pf.
    task automatic run_trial(input string tag, input int a, input int ps, input int d,
                             input int b, input int pf, input int xs);
        int  ec, ef, eend, ew, lim;
        bit  ecatch, eto, esat, seen, sd, fd, early;
        int  hold_c, hold_f, hold_w;
        ec = 0; ef = 0; eend = -1; ecatch = 0; eto = 0; esat = 0; seen = 1; early = 0;
        lim = d + b + NSYN + (TO + 3) * pf + 20;
        for (int t = 1; t <= lim && eend < 0; t++) begin
            sd = det(t, 1 + a, ps);
            fd = det(t, d + 1 + b, pf);
            if (t <= d) begin
                if (sd) begin
                    if (ec == CMAX) esat = 1; else ec++;
                end
            end else if (fd) begin
                if (sd || !seen) begin ef++; ecatch = 1; eend = t; end
                else if (ef == TO) begin eto = 1; eend = t; end
                else begin ef++; seen = 0; end
            end else if (sd) begin
                seen = 1;
            end
        end
        ew = 0;
        if (ecatch) begin
            ew = ec * K + ef;
            if (esat || ew > WMAX) begin ew = WMAX; esat = 1; end
        end

        @(negedge clk);
        for (int rel = 0; rel <= lim; rel++) begin
            start     = (rel == 0) || (xs > 0 && rel == xs);
            stop      = (rel == d);
            slow_edge = wave(rel, 1 + a, ps);
            fast_edge = wave(rel, d + 1 + b, pf);
            @(negedge clk);
            if (rel == 0) check("R2", {tag, " slow_en after start"}, slow_en, 1);
            if (rel == d && d < eend) check("R3", {tag, " fast_en after stop"}, fast_en, 1);
            if (rel < eend && done && !early) begin
                early = 1;
                check("R5", {tag, " done too early at rel"}, rel, eend);
            end
            if (rel == eend) begin
                check("R5", {tag, " done pulse"}, done, 1);
                check("R5", {tag, " enables off"}, {30'd0, slow_en, fast_en}, 0);
                check("R2", {tag, " coarse count"}, coarse_count, ec);
                check("R4", {tag, " fine count"}, fine_count, ef);
                check("R6", {tag, " result word"}, meas_word, ew);
                check("R7", {tag, " sat flag"}, sat, esat);
                check("R8", {tag, " timeout flag"}, timeout_err, eto);
                check("R8", {tag, " valid flag"}, valid, ecatch);
                break;
            end
        end
        if (eend < 0) check("R4", {tag, " no end predicted"}, 0, 1);
        hold_c = coarse_count; hold_f = fine_count; hold_w = meas_word;
        idle_cycles(8);
        check("R5", {tag, " done cleared"}, done, 0);
        check("R5", {tag, " counts held"}, (coarse_count == hold_c && fine_count == hold_f
                                           && meas_word == hold_w) ? 1 : 0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int hc, hf;
        void'($urandom(32'h5eed_7dc1));
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check("R1", "outputs after reset",
              {slow_en, fast_en, done, valid, sat, timeout_err} == 6'd0 &&
              coarse_count == 0 && fine_count == 0 && meas_word == 0 ? 1 : 0, 1);

        // R10: stop while idle, with edges toggling
        stop = 1; slow_edge = 1; fast_edge = 1;
        @(negedge clk);
        stop = 0; slow_edge = 0; fast_edge = 0;
        repeat (5) @(negedge clk);
        check("R10", "idle stop ignored", {slow_en, fast_en, done} == 3'd0 &&
              coarse_count == 0 && fine_count == 0 ? 1 : 0, 1);

        // Directed: plain catch-up
        run_trial("basic", 0, 10, 25, 2, 9, 0);
        // R3: stop on the same edge as a slow detection (slow det at 3 + 10k)
        run_trial("stop_on_slow_R3", 0, 10, 23, 0, 9, 0);
        // R9: catching edge arrives exactly when fine count reaches the limit
        run_trial("catch_at_limit_R9", 0, 48, 50, 38, 47, 0);
        // R8: lag one step longer gives a timeout
        run_trial("timeout_R8", 0, 48, 50, 39, 47, 0);
        // R8: equal periods never catch
        run_trial("equal_periods_R8", 0, 8, 20, 1, 8, 0);
        // R7: coarse counter saturation
        run_trial("coarse_sat_R7", 0, 6, 1600, 1, 5, 0);
        // R10: extra start during the measurement
        run_trial("extra_start_R10", 1, 9, 30, 3, 8, 12);

        // R1: reset in the middle of a measurement
        start = 1; @(negedge clk); start = 0;
        repeat (6) begin slow_edge = ~slow_edge; @(negedge clk); end
        stop = 1; @(negedge clk); stop = 0;
        rst = 1; @(negedge clk); rst = 0;
        check("R1", "reset mid measurement",
              {slow_en, fast_en, done, valid, sat, timeout_err} == 6'd0 &&
              coarse_count == 0 && fine_count == 0 && meas_word == 0 ? 1 : 0, 1);
        idle_cycles(8);

        // Random trials
        for (int i = 0; i < 40; i++) begin
            int ps, pf, a, d, b, xs;
            ps = 4 + int'($urandom_range(10));
            pf = 2 + int'($urandom_range(ps - 2));
            a  = int'($urandom_range(5));
            d  = 1 + int'($urandom_range(59));
            b  = int'($urandom_range(5));
            xs = ($urandom_range(3) == 0) ? 1 + int'($urandom_range(d - 1)) : 0;
            run_trial($sformatf("rand%0d_R4", i), a, ps, d, b, pf, xs);
        end

        // R10: stop while idle after a result leaves the held result alone
        hc = coarse_count; hf = fine_count;
        stop = 1; @(negedge clk); stop = 0;
        repeat (4) @(negedge clk);
        check("R10", "idle stop keeps result", (coarse_count == hc && fine_count == hf &&
              !fast_en && !slow_en) ? 1 : 0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule